// File: doc/BRIEF.md
# CPU Clock Source Selection Controller

This block picks which of three clock sources drives the CPU: an always-available internal high-speed oscillator, a main system clock, or a low-speed subsystem clock. The main clock can come from a crystal oscillator or straight from an external clock pin. Software programs four byte-wide registers through a simple write port:

- a one-shot mode register,
- a stabilization-time select register,
- an oscillator stop register,
- a clock-select register.

The analog oscillators sit outside the block. It sees each one only as an enable it drives and a "clock valid" flag it receives.

When the main crystal is started, a thermometer-coded status counter fills one bit per fixed step of counted cycles. A request for the main clock is held pending until the bit picked by the stabilization select register is set. For an external clock input no stabilization wait is applied. A pending request is carried out when its target becomes usable. The switch is break-before-make: the old gate drops, one cycle passes with every gate closed, and then the new gate opens. A status port tells software which source is driving the CPU.

Top module: `cksel_ctrl`

## Requirements
- R1: While reset is held and until it has been released synchronously (two clock edges after `rst_n` rises), `cur_src` is 0 (internal oscillator), `gate_en` is 3'b001, both oscillator enables are 0 and `stab_status` is all zeros.
- R2: The mode register (address 0) takes only the first write after reset. Every later write to address 0 is ignored until the next reset, and this is visible on `xtal_hi_range` and the oscillator enables.
- R3: `main_osc_en` equals mode bit 0 AND NOT stop bit 0. `sub_osc_en` equals mode bit 3 AND NOT stop bit 1. The stop register is address 2 and both stop bits reset to 1.
- R4: While `main_osc_en` is 0, `stab_status` is cleared. While the main crystal is enabled and `main_valid` is 1, one more bit (from bit 0 upward) is set after each 2^STEP_LOG2 counted cycles, until all bits are set.
- R5: In crystal mode (mode bit 1 = 0), a main-clock request (select register address 3, bit 0) is carried out only once `stab_status[S]` is 1, where S is stabilization select register address 1, bits [2:0]. It also needs `main_osc_en` and `main_valid`. Until then the request stays pending.
- R6: In external-clock mode (mode bit 1 = 1), the main clock is usable as soon as `main_osc_en` and `main_valid` are both 1. `stab_status` stays 0.
- R7: A switch is break-before-make. At most one gate is open. When the source changes, there is exactly one cycle with `gate_en` = 0 before the new gate opens.
- R8: Select bit 1 (subsystem) takes priority over select bit 0 (main). With neither bit set, the internal oscillator is targeted. The subsystem clock is usable when `sub_osc_en` and `sub_valid` are both 1.
- R9: A write that would set the stop bit of the oscillator currently driving the CPU leaves that stop bit unchanged.
- R10: `cur_src` encodes 0 = internal oscillator, 1 = main, 2 = subsystem. When `gate_en` is nonzero it equals 1 << `cur_src`.
- R11: `xtal_hi_range` follows mode bit 2, the crystal gain/frequency-range bit (set for crystals above 10 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mode, 1 stab select, 2 stop, 3 select) |
| wr_data | input | 8 | Write data |
| main_valid | input | 1 | Main clock is toggling |
| sub_valid | input | 1 | Subsystem clock is toggling and settled |
| main_osc_en | output | 1 | Main oscillator / input buffer enable |
| sub_osc_en | output | 1 | Subsystem oscillator enable |
| xtal_hi_range | output | 1 | Crystal high-frequency gain setting |
| stab_status | output | NSTEP | Thermometer stabilization status |
| cur_src | output | 2 | Source currently driving the CPU |
| gate_en | output | 3 | One-hot-or-zero clock gate enables (bit = source code) |

## Verification
A wrong internal state in this block shows up at the ports within one or two edges. A stabilization count that is off by one step moves the edge of `stab_status` and the cycle in which `gate_en` reopens on the main source. A write-once lock that fails flips `xtal_hi_range` on the very next edge. A switch sequencer that skips its closed-gate cycle, or that acts on a target that is not ready, changes `gate_en` and `cur_src` in a cycle where the reference model predicts no change. A cycle-exact comparison on every clock therefore localizes each fault to the edge where it occurs.

// File: rtl/cksel_pkg.sv
package cksel_pkg;
  typedef enum logic [1:0] {
    SRC_HIOSC = 2'd0,
    SRC_MAIN  = 2'd1,
    SRC_SUB   = 2'd2
  } src_e;

  localparam int NSRC = 3;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_STAB = 2'd1;
  localparam logic [1:0] ADDR_STOP = 2'd2;
  localparam logic [1:0] ADDR_SEL  = 2'd3;
endpackage

// File: rtl/cksel_regs.sv
module cksel_regs
  import cksel_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  src_e            cur_src,
  output logic            mode_main,
  output logic            mode_ext,
  output logic            mode_hi,
  output logic            mode_sub,
  output logic            locked,
  output logic [SELW-1:0] stab_sel,
  output logic            stop_main,
  output logic            stop_sub,
  output logic            sel_main,
  output logic            sel_sub
);
  logic [3:0]      mode_q, mode_d;
  logic            lock_q, lock_d;
  logic [SELW-1:0] ssel_q, ssel_d;
  logic [1:0]      stop_q, stop_d;
  logic [1:0]      csel_q, csel_d;

  always_comb begin
    mode_d = mode_q;
    lock_d = lock_q;
    ssel_d = ssel_q;
    stop_d = stop_q;
    csel_d = csel_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_MODE: if (!lock_q) begin
          mode_d = wr_data[3:0];
          lock_d = 1'b1;
        end
        ADDR_STAB: ssel_d = wr_data[SELW-1:0];
        ADDR_STOP: begin
          stop_d[0] = (cur_src == SRC_MAIN && wr_data[0]) ? stop_q[0] : wr_data[0];
          stop_d[1] = (cur_src == SRC_SUB  && wr_data[1]) ? stop_q[1] : wr_data[1];
        end
        default:   csel_d = wr_data[1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lock_q <= 1'b0;
      ssel_q <= '0;
      stop_q <= 2'b11;
      csel_q <= '0;
    end else begin
      mode_q <= mode_d;
      lock_q <= lock_d;
      ssel_q <= ssel_d;
      stop_q <= stop_d;
      csel_q <= csel_d;
    end
  end

  assign mode_main = mode_q[0];
  assign mode_ext  = mode_q[1];
  assign mode_hi   = mode_q[2];
  assign mode_sub  = mode_q[3];
  assign locked    = lock_q;
  assign stab_sel  = ssel_q;
  assign stop_main = stop_q[0];
  assign stop_sub  = stop_q[1];
  assign sel_main  = csel_q[0];
  assign sel_sub   = csel_q[1];
endmodule

// File: rtl/cksel_stab.sv
module cksel_stab #(
  parameter int NSTEP     = 8,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             osc_valid,
  input  logic             count_en,
  output logic [NSTEP-1:0] therm
);
  localparam logic [STEP_LOG2-1:0] PRE_LAST = {STEP_LOG2{1'b1}};

  logic [STEP_LOG2-1:0] pre_q, pre_d;
  logic [NSTEP-1:0]     th_q, th_d;
  logic                 tick;

  assign tick = osc_valid && count_en && !th_q[NSTEP-1];

  always_comb begin
    pre_d = pre_q;
    th_d  = th_q;
    if (!osc_en) begin
      pre_d = '0;
      th_d  = '0;
    end else if (tick) begin
      pre_d = pre_q + 1'b1;
      if (pre_q == PRE_LAST) th_d = {th_q[NSTEP-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      th_q  <= '0;
    end else begin
      pre_q <= pre_d;
      th_q  <= th_d;
    end
  end

  assign therm = th_q;
endmodule

// File: rtl/cksel_switch.sv
module cksel_switch
  import cksel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  src_e            tgt,
  input  logic            tgt_ready,
  output src_e            cur,
  output logic [NSRC-1:0] gate_en
);
  typedef enum logic {SW_RUN, SW_GAP} sw_e;

  sw_e  st_q, st_d;
  src_e cur_q, cur_d;
  src_e nxt_q, nxt_d;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    nxt_d = nxt_q;
    if (st_q == SW_RUN) begin
      if (tgt != cur_q && tgt_ready) begin
        st_d  = SW_GAP;
        nxt_d = tgt;
      end
    end else begin
      cur_d = nxt_q;
      st_d  = SW_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_RUN;
      cur_q <= SRC_HIOSC;
      nxt_q <= SRC_HIOSC;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      nxt_q <= nxt_d;
    end
  end

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_gate
    assign gate_en[gi] = (st_q == SW_RUN) && (cur_q == src_e'(gi));
  end

  assign cur = cur_q;
endmodule

// File: rtl/cksel_ctrl.sv
module cksel_ctrl
  import cksel_pkg::*;
#(
  parameter int NSTEP     = 8,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             main_valid,
  input  logic             sub_valid,
  output logic             main_osc_en,
  output logic             sub_osc_en,
  output logic             xtal_hi_range,
  output logic [NSTEP-1:0] stab_status,
  output logic [1:0]       cur_src,
  output logic [2:0]       gate_en
);
  localparam int SELW = $clog2(NSTEP);

  logic            rst_m_n, rst_q_n;
  logic            mode_main, mode_ext, mode_hi, mode_sub, mode_locked;
  logic [SELW-1:0] stab_sel;
  logic            stop_main, stop_sub, sel_main, sel_sub;
  logic            main_ready, sub_ready, tgt_ready;
  src_e            tgt, cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  cksel_regs #(.DW(8), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cur_src(cur),
    .mode_main(mode_main), .mode_ext(mode_ext), .mode_hi(mode_hi),
    .mode_sub(mode_sub), .locked(mode_locked), .stab_sel(stab_sel),
    .stop_main(stop_main), .stop_sub(stop_sub),
    .sel_main(sel_main), .sel_sub(sel_sub)
  );

  assign main_osc_en   = mode_main && !stop_main;
  assign sub_osc_en    = mode_sub && !stop_sub;
  assign xtal_hi_range = mode_hi;

  cksel_stab #(.NSTEP(NSTEP), .STEP_LOG2(STEP_LOG2)) u_stab (
    .clk(clk), .rst_n(rst_q_n), .osc_en(main_osc_en),
    .osc_valid(main_valid), .count_en(!mode_ext), .therm(stab_status)
  );

  assign main_ready = main_osc_en && main_valid && (mode_ext || stab_status[stab_sel]);
  assign sub_ready  = sub_osc_en && sub_valid;

  always_comb begin
    if (sel_sub) begin
      tgt = SRC_SUB;
      tgt_ready = sub_ready;
    end else if (sel_main) begin
      tgt = SRC_MAIN;
      tgt_ready = main_ready;
    end else begin
      tgt = SRC_HIOSC;
      tgt_ready = 1'b1;
    end
  end

  cksel_switch u_sw (
    .clk(clk), .rst_n(rst_q_n), .tgt(tgt), .tgt_ready(tgt_ready),
    .cur(cur), .gate_en(gate_en)
  );

  assign cur_src = cur;
endmodule

// File: rtl/cksel_ctrl_chk.sv
module cksel_ctrl_chk #(
  parameter int NSTEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       gate_en,
  input logic [1:0]       cur_src,
  input logic             main_osc_en,
  input logic             sub_osc_en,
  input logic             xtal_hi_range,
  input logic [NSTEP-1:0] stab_status,
  input logic             mode_locked,
  input logic             mode_ext
);
  a_r7_gates_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en));

  a_r7_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en != 3'b000 && $past(gate_en) != 3'b000) |-> gate_en == $past(gate_en));

  a_r10_gate_matches_src: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en != 3'b000) |-> gate_en == (3'b001 << cur_src));

  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> $stable(xtal_hi_range) && mode_locked);

  a_r4_stab_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |=> stab_status == '0);

  a_r9_main_kept_running: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src == 2'd1) |-> main_osc_en);

  a_r9_sub_kept_running: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src == 2'd2) |-> sub_osc_en);

  a_r5_xtal_waited: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_en[1]) && !mode_ext) |-> stab_status[0]);

  a_r6_ext_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext |=> stab_status == '0);
endmodule

bind cksel_ctrl cksel_ctrl_chk #(.NSTEP(NSTEP)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .gate_en(gate_en), .cur_src(cur_src),
  .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
  .xtal_hi_range(xtal_hi_range), .stab_status(stab_status),
  .mode_locked(mode_locked), .mode_ext(mode_ext)
);

// File: tb/cksel_ctrl_tb.sv
module cksel_ctrl_tb;
  localparam int NSTEP = 8;
  localparam int STEP_LOG2 = 2;
  localparam int STEP = 1 << STEP_LOG2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic main_valid = 1'b0;
  logic sub_valid = 1'b0;
  logic main_osc_en, sub_osc_en, xtal_hi_range;
  logic [NSTEP-1:0] stab_status;
  logic [1:0] cur_src;
  logic [2:0] gate_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  always #4 clk = ~clk;

  cksel_ctrl #(.NSTEP(NSTEP), .STEP_LOG2(STEP_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .main_valid(main_valid), .sub_valid(sub_valid),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
    .xtal_hi_range(xtal_hi_range), .stab_status(stab_status),
    .cur_src(cur_src), .gate_en(gate_en)
  );

  // behavioural reference model
  int m_rs1, m_rs2;
  int m_locked, m_main, m_ext, m_hi, m_sub;
  int m_ssel, m_stop_main, m_stop_sub, m_sel_main, m_sel_sub;
  int m_cnt, m_cur, m_gap, m_next;

  function automatic void model_reset();
    m_locked = 0; m_main = 0; m_ext = 0; m_hi = 0; m_sub = 0;
    m_ssel = 0; m_stop_main = 1; m_stop_sub = 1; m_sel_main = 0; m_sel_sub = 0;
    m_cnt = 0; m_cur = 0; m_gap = 0; m_next = 0;
  endfunction

  function automatic int steps_done();
    int s = m_cnt / STEP;
    return (s > NSTEP) ? NSTEP : s;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_reset();
    end else begin
      if (m_rs2 == 0) begin
        model_reset();
      end else begin
        int men, sen, tgt, rdy;
        int n_cnt, n_cur, n_gap, n_next;
        men = m_main & ~m_stop_main & 1;
        sen = m_sub & ~m_stop_sub & 1;
        if (m_sel_sub) begin tgt = 2; rdy = sen && sub_valid; end
        else if (m_sel_main) begin
          tgt = 1; rdy = men && main_valid && (m_ext || steps_done() >= m_ssel + 1);
        end else begin tgt = 0; rdy = 1; end
        n_cnt = m_cnt;
        if (!men) n_cnt = 0;
        else if (main_valid && !m_ext && m_cnt < NSTEP * STEP) n_cnt = m_cnt + 1;
        n_cur = m_cur; n_gap = m_gap; n_next = m_next;
        if (m_gap) begin n_cur = m_next; n_gap = 0; end
        else if (tgt != m_cur && rdy) begin n_gap = 1; n_next = tgt; end
        if (wr_en) begin
          case (wr_addr)
            2'd0: if (!m_locked) begin
              m_locked = 1; m_main = wr_data[0]; m_ext = wr_data[1];
              m_hi = wr_data[2]; m_sub = wr_data[3];
            end
            2'd1: m_ssel = wr_data[2:0];
            2'd2: begin
              if (!(m_cur == 1 && wr_data[0])) m_stop_main = wr_data[0];
              if (!(m_cur == 2 && wr_data[1])) m_stop_sub = wr_data[1];
            end
            default: begin m_sel_main = wr_data[0]; m_sel_sub = wr_data[1]; end
          endcase
        end
        m_cnt = n_cnt; m_cur = n_cur; m_gap = n_gap; m_next = n_next;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      int e_gate, e_stab;
      e_gate = m_gap ? 0 : (1 << m_cur);
      e_stab = (1 << steps_done()) - 1;
      check(cur_src == m_cur[1:0], "R10 cur_src", cur_src, m_cur);
      check(gate_en == e_gate[2:0], "R7 gate_en", gate_en, e_gate);
      check(stab_status == e_stab[NSTEP-1:0], "R4 stab_status", stab_status, e_stab);
      check(main_osc_en == (m_main & ~m_stop_main & 1), "R3 main_osc_en", main_osc_en,
            m_main & ~m_stop_main & 1);
      check(sub_osc_en == (m_sub & ~m_stop_sub & 1), "R3 sub_osc_en", sub_osc_en,
            m_sub & ~m_stop_sub & 1);
      check(xtal_hi_range == m_hi[0], "R11 xtal_hi_range", xtal_hi_range, m_hi);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    main_valid = 1'b0; sub_valid = 1'b0;
    idle(3);
    check(cur_src == 2'd0 && gate_en == 3'b001, "R1 reset source", gate_en, 1);
    check(!main_osc_en && !sub_osc_en && stab_status == '0, "R1 reset enables",
          {main_osc_en, sub_osc_en}, 0);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R5: main request before the oscillator is configured stays pending
    wr(2'd3, 8'h01);
    idle(5);
    check(cur_src == 2'd0, "R5 pending without oscillator", cur_src, 0);
    // mode: crystal main, high range, subsystem enabled
    wr(2'd0, 8'h0D);
    check(xtal_hi_range == 1'b1, "R11 range bit", xtal_hi_range, 1);
    // R2: second write to the mode register is ignored
    wr(2'd0, 8'h02);
    idle(1);
    check(xtal_hi_range == 1'b1, "R2 write-once range", xtal_hi_range, 1);
    wr(2'd1, 8'h02);
    main_valid = 1'b1;
    wr(2'd2, 8'h02);
    check(main_osc_en == 1'b1, "R3 main start", main_osc_en, 1);
    idle(6);
    check(cur_src == 2'd0, "R5 waits for stabilization", cur_src, 0);
    idle(20);
    check(cur_src == 2'd1 && gate_en == 3'b010, "R5 main selected", cur_src, 1);
    check(stab_status[2] == 1'b1, "R4 threshold reached", stab_status, 7);
    // R9: stopping the running main oscillator is ignored
    wr(2'd2, 8'h03);
    idle(2);
    check(main_osc_en == 1'b1 && cur_src == 2'd1, "R9 stop ignored", main_osc_en, 1);
    // R8: subsystem request, priority over main, waits for sub_valid
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h03);
    idle(4);
    check(cur_src == 2'd1, "R8 sub pending", cur_src, 1);
    sub_valid = 1'b1;
    idle(4);
    check(cur_src == 2'd2 && gate_en == 3'b100, "R8 sub selected", cur_src, 2);
    // R4: stop the main oscillator, status clears
    wr(2'd2, 8'h01);
    idle(2);
    check(!main_osc_en && stab_status == '0, "R4 cleared on stop", stab_status, 0);
    wr(2'd3, 8'h00);
    idle(4);
    check(cur_src == 2'd0, "R10 back to internal", cur_src, 0);
    wr(2'd2, 8'h03);
    idle(2);
    check(!sub_osc_en, "R3 sub stopped", sub_osc_en, 0);
    // R6: external clock input, no stabilization wait
    do_reset();
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h07);
    main_valid = 1'b1;
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h01);
    idle(3);
    check(cur_src == 2'd1, "R6 external selected", cur_src, 1);
    check(stab_status == '0, "R6 no counting", stab_status, 0);
    idle(10);
    finish_run();
  end
endmodule